// File: doc/BRIEF.md
# Detector Readout Timing Sequencer

This block drives the control strobes of a multichannel charge-integrating front end from a single host frame trigger. Each frame runs a fixed order of phases. The integrator reset comes first, then the reset sample, then integration, then the signal sample. Each of these phases lasts a programmable number of clock cycles. A single-cycle start-of-readout pulse follows at the earliest legal point. Readout therefore begins right after the signal sample and well ahead of the next reset. The block then holds in a data-read phase until the front end reports conversion complete. After that it parks in a wait state until the next trigger.

The block also produces a gated readout clock. This clock runs throughout a frame. After the reset strobe falls, the front end needs a mode-dependent number of further clock edges: 133 in sequential mode and 33 in simultaneous mode. When the frame ends before that count is reached, the clock keeps running in the wait state until the count is complete and then stops. A configuration input can keep the clock free running instead. The gate enable is captured on the falling edge of the source clock, so the gated clock never carries a runt pulse.

A trigger that arrives while a frame is still active does not disturb that frame. It is reported as an overrun. Every frame reports its completion with a one-cycle done pulse.

FSM states, in frame order:
- `PH_IDLE` is the state after reset.
- `PH_RST`, `PH_RSAMP`, `PH_INTEG` and `PH_SSAMP` are the four timed phases.
- `PH_GAP_A`, `PH_GAP_B`, `PH_GAP_C` and `PH_GAP_D` are the one-cycle gaps, one after each timed phase.
- `PH_START` carries the start-of-readout pulse.
- `PH_READ` holds until conversion is complete.
- `PH_WAIT` is the parked state after a frame.

FSM transitions:
- `PH_IDLE` or `PH_WAIT` moves to `PH_RST` on a trigger.
- Each timed phase moves to the gap that follows it when its count expires.
- Each gap moves on after one cycle, and `PH_GAP_D` moves to `PH_START`.
- `PH_START` moves to `PH_READ` after one cycle.
- `PH_READ` moves to `PH_WAIT` on conversion done.

Top module: `readout_sequencer`

## Requirements
- R1: While reset is held, all strobes, `frame_done_o` and `overrun_o` are low, and `rd_clk_o` stays low. After reset the block is idle and the readout clock is stopped unless `clk_free` is 1.
- R2: A trigger sampled high in idle or wait makes `int_reset_o` rise one cycle later. It stays high for `len_reset` cycles, and a length of 0 acts as 1.
- R3: The timed phases run in a fixed order: integrator reset, then reset sample (`len_rsamp`), then integrate (`len_integ`), then signal sample (`len_ssamp`). Each lasts its programmed length, with 0 acting as 1. Exactly one cycle with every strobe low separates two phases, and no two strobes are ever high together.
- R4: `read_start_o` is high for exactly one cycle. It comes after the one-cycle gap that follows the signal sample, and the data-read phase starts in the next cycle.
- R5: `conv_done` sampled high during the data-read phase raises `frame_done_o` for one cycle in the next cycle and puts the block in wait. `conv_done` in any other phase is ignored.
- R6: The readout clock delivers a rising edge in every cycle that follows a cycle spent in an active phase, one cycle behind the state. After `int_reset_o` falls, when the frame ends early enough, exactly 133 rising edges (`mode_simul`=0) or 33 rising edges (`mode_simul`=1) are delivered before the clock stops in wait or idle.
- R7: With `clk_free`=1, the readout clock runs every cycle, even after the post-reset count is complete. Clearing `clk_free` stops it again within one cycle.
- R8: A trigger sampled high during an active phase raises `overrun_o` for one cycle in the next cycle and leaves the running frame's strobes unchanged.
- R9: A trigger received in wait starts a new frame at once, even while the post-reset clocks are still running. The post-reset count restarts at the new reset falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_trig | input | 1 | Host frame trigger, sampled each cycle |
| len_reset | input | LEN_W | Integrator reset length in cycles (0 acts as 1) |
| len_rsamp | input | LEN_W | Reset-sample length in cycles (0 acts as 1) |
| len_integ | input | LEN_W | Integrate length in cycles (0 acts as 1) |
| len_ssamp | input | LEN_W | Signal-sample length in cycles (0 acts as 1) |
| mode_simul | input | 1 | 1 = simultaneous readout (33 post-reset clocks), 0 = sequential (133) |
| clk_free | input | 1 | 1 = readout clock never stopped |
| conv_done | input | 1 | End-of-conversion indication from the front end |
| int_reset_o | output | 1 | Integrator reset strobe |
| samp_rst_o | output | 1 | Reset-level sample strobe |
| integrate_o | output | 1 | Integrate strobe |
| samp_sig_o | output | 1 | Signal-level sample strobe |
| read_start_o | output | 1 | Start-of-readout pulse |
| rd_clk_o | output | 1 | Gated readout clock |
| frame_done_o | output | 1 | One-cycle pulse per completed frame |
| overrun_o | output | 1 | One-cycle pulse for a trigger lost during a frame |

## Verification
A state register stuck or advanced early shows up at the strobe pins in the very next cycle. Because the strobes are registered from the next state, the comparison catches the first cycle that a phase runs too long, too short or out of order. A wrong post-reset clock counter, or a wrong gate enable, shows one cycle later as a missing or extra rising edge on the readout clock. A counter that is wrong only in its end value shows as an edge total different from 133 or 33 by the end of the wait period.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RST,
        PH_GAP_A,
        PH_RSAMP,
        PH_GAP_B,
        PH_INTEG,
        PH_GAP_C,
        PH_SSAMP,
        PH_GAP_D,
        PH_START,
        PH_READ,
        PH_WAIT
    } phase_e;

    // A frame is active in every phase except the two parked ones.
    function automatic logic phase_active(phase_e p);
        return !((p == PH_IDLE) || (p == PH_WAIT));
    endfunction

endpackage

// File: rtl/rseq_fsm.sv
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_trig,
    input  logic [LEN_W-1:0] len_reset,
    input  logic [LEN_W-1:0] len_rsamp,
    input  logic [LEN_W-1:0] len_integ,
    input  logic [LEN_W-1:0] len_ssamp,
    input  logic             conv_done,
    output logic             int_reset_o,
    output logic             samp_rst_o,
    output logic             integrate_o,
    output logic             samp_sig_o,
    output logic             read_start_o,
    output logic             frame_done_o,
    output logic             overrun_o,
    output logic             busy,
    output logic             rst_end
);

    phase_e           st_q, st_d;
    logic [LEN_W-1:0] cnt_q;
    logic             load;
    logic [LEN_W-1:0] load_len;

    // Remaining-cycle value to load so that a phase lasts max(len,1) cycles.
    function automatic logic [LEN_W-1:0] len_m1(logic [LEN_W-1:0] v);
        return (v == '0) ? '0 : v - LEN_W'(1);
    endfunction

    // Next-state logic.
    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        load_len = '0;
        unique case (st_q)
            PH_IDLE, PH_WAIT: begin
                if (frame_trig) begin
                    st_d     = PH_RST;
                    load     = 1'b1;
                    load_len = len_reset;
                end
            end
            PH_RST:   if (cnt_q == '0) st_d = PH_GAP_A;
            PH_GAP_A: begin
                st_d     = PH_RSAMP;
                load     = 1'b1;
                load_len = len_rsamp;
            end
            PH_RSAMP: if (cnt_q == '0) st_d = PH_GAP_B;
            PH_GAP_B: begin
                st_d     = PH_INTEG;
                load     = 1'b1;
                load_len = len_integ;
            end
            PH_INTEG: if (cnt_q == '0) st_d = PH_GAP_C;
            PH_GAP_C: begin
                st_d     = PH_SSAMP;
                load     = 1'b1;
                load_len = len_ssamp;
            end
            PH_SSAMP: if (cnt_q == '0) st_d = PH_GAP_D;
            PH_GAP_D: st_d = PH_START;
            PH_START: st_d = PH_READ;
            PH_READ:  if (conv_done) st_d = PH_WAIT;
            default:  st_d = PH_IDLE;
        endcase
    end

    // State register and phase counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (load) begin
                cnt_q <= len_m1(load_len);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - LEN_W'(1);
            end
        end
    end

    // Registered outputs, aligned with the state they belong to.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_reset_o  <= 1'b0;
            samp_rst_o   <= 1'b0;
            integrate_o  <= 1'b0;
            samp_sig_o   <= 1'b0;
            read_start_o <= 1'b0;
            frame_done_o <= 1'b0;
            overrun_o    <= 1'b0;
        end else begin
            int_reset_o  <= (st_d == PH_RST);
            samp_rst_o   <= (st_d == PH_RSAMP);
            integrate_o  <= (st_d == PH_INTEG);
            samp_sig_o   <= (st_d == PH_SSAMP);
            read_start_o <= (st_d == PH_START);
            frame_done_o <= (st_q == PH_READ) && conv_done;
            overrun_o    <= frame_trig && phase_active(st_q);
        end
    end

    assign busy    = phase_active(st_q);
    assign rst_end = (st_q == PH_RST) && (st_d != PH_RST);

endmodule

// File: rtl/rseq_tail.sv
module rseq_tail #(
    parameter int SEQ_TAIL = 133,
    parameter int SIM_TAIL = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_end,
    input  logic clk_live,
    input  logic mode_simul,
    output logic tail_open
);

    localparam int MAX_TAIL = (SEQ_TAIL > SIM_TAIL) ? SEQ_TAIL : SIM_TAIL;
    localparam int CW       = $clog2(MAX_TAIL + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] need;

    assign need = mode_simul ? CW'(SIM_TAIL) : CW'(SEQ_TAIL);

    // Counts delivered gated-clock edges after the reset strobe falls.
    // Out of reset the count starts full, so nothing is owed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(MAX_TAIL);
        end else if (rst_end) begin
            cnt_q <= '0;
        end else if (clk_live && (cnt_q < need)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tail_open = (cnt_q < need);

endmodule

// File: rtl/rseq_clkgate.sv
module rseq_clkgate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic en_q,
    output logic gclk
);

    // The enable changes only while clk is low, so the gated clock is glitch free.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en;
        end
    end

    assign gclk = clk & en_q;

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer #(
    parameter int LEN_W    = 16,
    parameter int SEQ_TAIL = 133,
    parameter int SIM_TAIL = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_trig,
    input  logic [LEN_W-1:0] len_reset,
    input  logic [LEN_W-1:0] len_rsamp,
    input  logic [LEN_W-1:0] len_integ,
    input  logic [LEN_W-1:0] len_ssamp,
    input  logic             mode_simul,
    input  logic             clk_free,
    input  logic             conv_done,
    output logic             int_reset_o,
    output logic             samp_rst_o,
    output logic             integrate_o,
    output logic             samp_sig_o,
    output logic             read_start_o,
    output logic             rd_clk_o,
    output logic             frame_done_o,
    output logic             overrun_o
);

    logic fsm_busy;
    logic fsm_rst_end;
    logic tail_open;
    logic gate_en;
    logic gate_en_q;

    rseq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_trig   (frame_trig),
        .len_reset    (len_reset),
        .len_rsamp    (len_rsamp),
        .len_integ    (len_integ),
        .len_ssamp    (len_ssamp),
        .conv_done    (conv_done),
        .int_reset_o  (int_reset_o),
        .samp_rst_o   (samp_rst_o),
        .integrate_o  (integrate_o),
        .samp_sig_o   (samp_sig_o),
        .read_start_o (read_start_o),
        .frame_done_o (frame_done_o),
        .overrun_o    (overrun_o),
        .busy         (fsm_busy),
        .rst_end      (fsm_rst_end)
    );

    rseq_tail #(.SEQ_TAIL(SEQ_TAIL), .SIM_TAIL(SIM_TAIL)) u_tail (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_end    (fsm_rst_end),
        .clk_live   (gate_en_q),
        .mode_simul (mode_simul),
        .tail_open  (tail_open)
    );

    assign gate_en = fsm_busy | clk_free | tail_open;

    rseq_clkgate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (gate_en),
        .en_q  (gate_en_q),
        .gclk  (rd_clk_o)
    );

endmodule

// File: rtl/readout_sequencer_chk.sv
module readout_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_trig,
    input logic conv_done,
    input logic int_reset_o,
    input logic samp_rst_o,
    input logic integrate_o,
    input logic samp_sig_o,
    input logic read_start_o,
    input logic frame_done_o,
    input logic overrun_o,
    input logic busy,
    input logic gate_en
);

    logic [4:0] strobes;
    assign strobes = {int_reset_o, samp_rst_o, integrate_o, samp_sig_o, read_start_o};

    p_trig_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_trig && !busy) |=> int_reset_o);

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(int_reset_o) || $fell(samp_rst_o) || $fell(integrate_o) || $fell(samp_sig_o))
        |-> (strobes == 5'b0));

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        read_start_o |=> !read_start_o);

    p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> $past(conv_done));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    p_clk_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> gate_en);

    p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> $past(frame_trig));

endmodule

bind readout_sequencer readout_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_trig   (frame_trig),
    .conv_done    (conv_done),
    .int_reset_o  (int_reset_o),
    .samp_rst_o   (samp_rst_o),
    .integrate_o  (integrate_o),
    .samp_sig_o   (samp_sig_o),
    .read_start_o (read_start_o),
    .frame_done_o (frame_done_o),
    .overrun_o    (overrun_o),
    .busy         (fsm_busy),
    .gate_en      (gate_en_q)
);

// File: tb/readout_sequencer_bench.sv
module readout_sequencer_bench;

    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_trig = 1'b0;
    logic          mode_simul = 1'b0;
    logic          clk_free = 1'b0;
    logic          conv_done = 1'b0;
    logic [LW-1:0] len_reset = 16'd1;
    logic [LW-1:0] len_rsamp = 16'd1;
    logic [LW-1:0] len_integ = 16'd1;
    logic [LW-1:0] len_ssamp = 16'd1;

    logic int_reset_o, samp_rst_o, integrate_o, samp_sig_o, read_start_o;
    logic rd_clk_o, frame_done_o, overrun_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference model: phase index (0 idle, 1 reset, 2 gap, 3 reset sample,
    // 4 gap, 5 integrate, 6 gap, 7 signal sample, 8 gap, 9 start, 10 read, 11 wait)
    int ph = 0;
    int rem = 0;
    int m_tail = 1000;
    bit en_m = 1'b0;
    bit e_done = 1'b0;
    bit e_ovr = 1'b0;

    int  edge_cnt = 0;
    bit  counting = 1'b0;
    bit  prev_rst = 1'b0;

    readout_sequencer u_readout_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_trig   (frame_trig),
        .len_reset    (len_reset),
        .len_rsamp    (len_rsamp),
        .len_integ    (len_integ),
        .len_ssamp    (len_ssamp),
        .mode_simul   (mode_simul),
        .clk_free     (clk_free),
        .conv_done    (conv_done),
        .int_reset_o  (int_reset_o),
        .samp_rst_o   (samp_rst_o),
        .integrate_o  (integrate_o),
        .samp_sig_o   (samp_sig_o),
        .read_start_o (read_start_o),
        .rd_clk_o     (rd_clk_o),
        .frame_done_o (frame_done_o),
        .overrun_o    (overrun_o)
    );

    always #5 clk = ~clk;

    function automatic int eff(logic [LW-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int need;
        need = mode_simul ? 33 : 133;
        en_m = ((ph != 0) && (ph != 11)) || clk_free || (m_tail < need);
        if (ph == 1 && rem == 1) m_tail = 0;
        else if (en_m && m_tail < need) m_tail++;
        e_ovr  = frame_trig && (ph != 0) && (ph != 11);
        e_done = 1'b0;
        case (ph)
            0, 11: if (frame_trig) begin ph = 1; rem = eff(len_reset); end
            1, 3, 5, 7: if (rem == 1) ph++; else rem--;
            2: begin ph = 3; rem = eff(len_rsamp); end
            4: begin ph = 5; rem = eff(len_integ); end
            6: begin ph = 7; rem = eff(len_ssamp); end
            8: ph = 9;
            9: ph = 10;
            10: if (conv_done) begin ph = 11; e_done = 1'b1; end
            default: ph = 0;
        endcase
    endtask

    task automatic compare();
        chk(int_reset_o == (ph == 1), "R2 int_reset_o", int'(int_reset_o), int'(ph == 1));
        chk(samp_rst_o == (ph == 3), "R3 samp_rst_o", int'(samp_rst_o), int'(ph == 3));
        chk(integrate_o == (ph == 5), "R3 integrate_o", int'(integrate_o), int'(ph == 5));
        chk(samp_sig_o == (ph == 7), "R3 samp_sig_o", int'(samp_sig_o), int'(ph == 7));
        chk(read_start_o == (ph == 9), "R4 read_start_o", int'(read_start_o), int'(ph == 9));
        chk(frame_done_o == e_done, "R5 frame_done_o", int'(frame_done_o), int'(e_done));
        chk(overrun_o == e_ovr, "R8 overrun_o", int'(overrun_o), int'(e_ovr));
        chk(rd_clk_o == en_m, "R6 rd_clk_o", int'(rd_clk_o), int'(en_m));
        if (counting && rd_clk_o) edge_cnt++;
        if (prev_rst && !int_reset_o) begin
            counting = 1'b1;
            edge_cnt = 0;
        end
        prev_rst = int_reset_o;
    endtask

    // Edge at +0, model at +1, sample at +2, inputs may change at +4.
    task automatic tick();
        @(posedge clk);
        #1 model_step();
        #1 compare();
        #2;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_phase(int p);
        for (int i = 0; i < 500 && ph != p; i++) tick();
    endtask

    task automatic trigger();
        frame_trig = 1'b1;
        tick();
        frame_trig = 1'b0;
    endtask

    task automatic finish_read(int n);
        wait_phase(10);
        ticks(n);
        conv_done = 1'b1;
        tick();
        conv_done = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk({int_reset_o, samp_rst_o, integrate_o, samp_sig_o, read_start_o,
             frame_done_o, overrun_o, rd_clk_o} == 8'b0, "R1 outputs in reset",
            int'({int_reset_o, samp_rst_o, integrate_o, samp_sig_o, read_start_o,
                  frame_done_o, overrun_o, rd_clk_o}), 0);
        #2 rst_n = 1'b1;
        ticks(4);
        chk(rd_clk_o == 1'b0, "R1 clock stopped in idle", int'(rd_clk_o), 0);

        // Sequential frame, stray conversion-done pulse, overrun.
        len_reset = 16'd3; len_rsamp = 16'd2; len_integ = 16'd4; len_ssamp = 16'd2;
        trigger();
        wait_phase(3);
        trigger();                     // R8: lost trigger
        wait_phase(5);
        conv_done = 1'b1;              // R5: ignored outside read
        tick();
        conv_done = 1'b0;
        finish_read(40);
        ticks(200);
        chk(edge_cnt == 133, "R6 sequential post-reset edges", edge_cnt, 133);
        chk(rd_clk_o == 1'b0, "R6 clock stopped after tail", int'(rd_clk_o), 0);

        // Simultaneous mode, zero lengths act as one.
        mode_simul = 1'b1;
        len_reset = 16'd0; len_rsamp = 16'd0; len_integ = 16'd0; len_ssamp = 16'd0;
        trigger();
        finish_read(3);
        ticks(100);
        chk(edge_cnt == 33, "R6 simultaneous post-reset edges", edge_cnt, 33);

        // R9: restart from wait while post-reset clocks still run.
        mode_simul = 1'b0;
        len_reset = 16'd2; len_rsamp = 16'd1; len_integ = 16'd3; len_ssamp = 16'd1;
        trigger();
        finish_read(5);
        ticks(10);
        chk(rd_clk_o == 1'b1, "R9 clock still running in wait", int'(rd_clk_o), 1);
        trigger();
        chk(int_reset_o == 1'b1, "R9 new frame from wait", int'(int_reset_o), 1);
        finish_read(20);
        ticks(200);
        chk(edge_cnt == 133, "R9 count restarted at new reset", edge_cnt, 133);

        // R7: free-running clock.
        clk_free = 1'b1;
        ticks(20);
        chk(rd_clk_o == 1'b1, "R7 free-running clock", int'(rd_clk_o), 1);
        clk_free = 1'b0;
        ticks(3);
        chk(rd_clk_o == 1'b0, "R7 clock stops when cleared", int'(rd_clk_o), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule